// File: doc/BRIEF.md
# Selectable Timer Clock Generator

This block turns one 8-bit configuration byte into two single-cycle clock enables in the system clock domain. The first is a capture tick, which paces a free-running capture counter. The second is an interval tick, which paces a periodic interval timer. Each tick has its own 2-bit source field and its own 2-bit divider field. A source can be one of these:

- a fast main-oscillator enable;
- a slow low-power enable;
- an edge-detected external clock pin.

The capture tick has a code that switches it off. The interval tick has a code that chains it to the already-divided capture tick.

Every source pulse is counted by a small divider. The divider emits one enable each time its count reaches the end of its period. Loading a new value into a tick's fields restarts that tick's divider, so the first period after the change has its full length. The external pin is asynchronous. It passes through a synchronizer, and each rising edge becomes exactly one source pulse.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst` is high, `cfg_q` reads 8'h8F and both ticks stay low. 8'h8F means the capture tick uses main/÷6 and the interval tick is chained/÷4.
- R2: On a clock edge with `cfg_wr` high, `cfg_q` takes `cfg_wdata`. The field layout is: capture divider [7:6], capture source [5:4], interval divider [3:2], interval source [1:0].
- R3: The capture divider codes 00/01/10/11 give one capture tick per 2/4/6/8 source pulses.
- R4: The capture source codes are 00 = `main_en`, 01 = external pin, 10 = `slow_en`. Pulses on the inputs that are not selected have no effect.
- R5: Capture source code 11 holds `cap_tick` low.
- R6: The interval divider codes 00/01/10/11 give one interval tick per 1/2/3/4 source pulses. Code 00 passes every source pulse through.
- R7: The interval source codes 00/01/10 select the same inputs as the capture field. Code 11 counts capture ticks, so each interval tick comes one cycle after a capture tick. When the capture tick is off, the chained interval tick stays low.
- R8: The external pin goes through a two-flop synchronizer, and each rising edge gives one source pulse. A pin held high gives only one pulse. The tick for a rise set up before edge k appears after edge k+2.
- R9: Each tick is one cycle wide. After a divider restart, its first tick appears after the clock edge that samples its N-th source pulse. Every later tick appears after each further N-th pulse.
- R10: A write that changes a tick's divider or source field restarts that tick's count at zero. A write that leaves that tick's fields unchanged does not disturb its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to write |
| main_en | input | 1 | Fast main-oscillator enable |
| slow_en | input | 1 | Slow low-power enable |
| ext_clk | input | 1 | Asynchronous external clock pin |
| cfg_q | output | 8 | Current configuration byte |
| cap_tick | output | 1 | Divided capture enable, one cycle wide |
| ivl_tick | output | 1 | Divided interval enable, one cycle wide |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and a 3-bit divider count. The ÷8 capture ratio therefore drives the count to its all-ones terminal value, and external edges show their full three-edge latency. Directed runs use a steady, a gapped, a slow and an external source, plus the chained mode. For each run the bench predicts the edge of the first tick after a restart and the number of ticks in the window. It also checks that a write touching only the other tick's fields keeps the running phase.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int unsigned CFG_W      = 8;
    localparam int unsigned DIV_CNT_W  = 3;
    localparam logic [CFG_W-1:0] CFG_RESET = 8'h8F;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_ALT  = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic [1:0] div;
        src_sel_e   sel;
    } tick_cfg_t;

    typedef struct packed {
        tick_cfg_t cap;
        tick_cfg_t ivl;
    } clk_cfg_t;

    // Terminal count of the capture divider: ratio 2*(code+1), last = ratio-1.
    function automatic logic [DIV_CNT_W-1:0] cap_last(input logic [1:0] code);
        logic [DIV_CNT_W-1:0] ratio;
        ratio = DIV_CNT_W'(2 * (int'(code) + 1) - 1);
        return ratio;
    endfunction

    // Terminal count of the interval divider: ratio code+1, last = code.
    function automatic logic [DIV_CNT_W-1:0] ivl_last(input logic [1:0] code);
        return DIV_CNT_W'(code);
    endfunction

endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            hist_q <= sync_q[LAST];
        end
    end

    assign rise_pulse = sync_q[LAST] & ~hist_q;

endmodule

// File: rtl/tick_src_mux.sv
module tick_src_mux
    import tick_pkg::*;
(
    input  src_sel_e sel,
    input  logic     main_en,
    input  logic     ext_en,
    input  logic     slow_en,
    input  logic     alt_en,
    output logic     src_en
);
    always_comb begin
        unique case (sel)
            SRC_MAIN: src_en = main_en;
            SRC_EXT:  src_en = ext_en;
            SRC_SLOW: src_en = slow_en;
            SRC_ALT:  src_en = alt_en;
            default:  src_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             src_en,
    input  logic [CNT_W-1:0] last,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (src_en) begin
                if (cnt_q >= last) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
    import tick_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = DIV_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             main_en,
    input  logic             slow_en,
    input  logic             ext_clk,
    output logic [CFG_W-1:0] cfg_q,
    output logic             cap_tick,
    output logic             ivl_tick
);
    clk_cfg_t cfg_r;
    clk_cfg_t cfg_next;
    logic     cap_clr;
    logic     ivl_clr;
    logic     ext_en;
    logic     cap_src;
    logic     ivl_src;
    logic     cap_tick_w;
    logic     ivl_tick_w;

    assign cfg_next = clk_cfg_t'(cfg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r <= clk_cfg_t'(CFG_RESET);
        end else if (cfg_wr) begin
            cfg_r <= cfg_next;
        end
    end

    // A write restarts only the divider whose own fields change.
    assign cap_clr = cfg_wr && (cfg_next.cap != cfg_r.cap);
    assign ivl_clr = cfg_wr && (cfg_next.ivl != cfg_r.ivl);

    tick_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_ext_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (ext_clk),
        .rise_pulse (ext_en)
    );

    // Capture channel: the alternate code is the off state.
    tick_src_mux u_cap_mux (
        .sel     (cfg_r.cap.sel),
        .main_en (main_en),
        .ext_en  (ext_en),
        .slow_en (slow_en),
        .alt_en  (1'b0),
        .src_en  (cap_src)
    );

    tick_divider #(
        .CNT_W (CNT_W)
    ) u_cap_div (
        .clk    (clk),
        .rst    (rst),
        .clr    (cap_clr),
        .src_en (cap_src),
        .last   (CNT_W'(cap_last(cfg_r.cap.div))),
        .tick   (cap_tick_w)
    );

    // Interval channel: the alternate code chains to the capture tick.
    tick_src_mux u_ivl_mux (
        .sel     (cfg_r.ivl.sel),
        .main_en (main_en),
        .ext_en  (ext_en),
        .slow_en (slow_en),
        .alt_en  (cap_tick_w),
        .src_en  (ivl_src)
    );

    tick_divider #(
        .CNT_W (CNT_W)
    ) u_ivl_div (
        .clk    (clk),
        .rst    (rst),
        .clr    (ivl_clr),
        .src_en (ivl_src),
        .last   (CNT_W'(ivl_last(cfg_r.ivl.div))),
        .tick   (ivl_tick_w)
    );

    assign cfg_q    = cfg_r;
    assign cap_tick = cap_tick_w;
    assign ivl_tick = ivl_tick_w;

endmodule

// File: rtl/timer_tick_gen_checker.sv
module timer_tick_gen_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_q,
    input logic       cap_tick,
    input logic       ivl_tick
);
    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (cfg_q == 8'h8F));

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (!cap_tick && !ivl_tick));

    a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_q == $past(cfg_wdata)));

    a_r3_cap_single_cycle: assert property (@(posedge clk) disable iff (rst)
        cap_tick |=> !cap_tick);

    a_r5_cap_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[5:4] == 2'b11) |=> !cap_tick);

    a_r7_chain_follows: assert property (@(posedge clk) disable iff (rst)
        ((cfg_q[1:0] == 2'b11) && !cap_tick) |=> !ivl_tick);

endmodule

bind timer_tick_gen timer_tick_gen_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .cap_tick  (cap_tick),
    .ivl_tick  (ivl_tick)
);

// File: tb/timer_tick_gen_test.sv
module timer_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       main_en = 1'b0;
    logic       slow_en = 1'b0;
    logic       ext_clk = 1'b0;
    logic [7:0] cfg_q;
    logic       cap_tick;
    logic       ivl_tick;

    int n_chk = 0;
    int n_err = 0;

    int n_cap, n_ivl, first_cap, first_ivl, lag_err, dbl_err;

    always #10 clk = ~clk;

    timer_tick_gen uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .main_en   (main_en),
        .slow_en   (slow_en),
        .ext_clk   (ext_clk),
        .cfg_q     (cfg_q),
        .cap_tick  (cap_tick),
        .ivl_tick  (ivl_tick)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge; the write is taken at the next posedge, returns at the following negedge.
    task automatic write_cfg(input logic [7:0] val);
        cfg_wr    = 1'b1;
        cfg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_inputs(input int i, input int fmode, input bit slow_on, input int emode);
        main_en = (fmode == 1) || (fmode == 2 && (i % 2 == 0));
        slow_en = slow_on && (i % 5 == 0);
        ext_clk = (emode == 1) ? ((i < 64) && (i % 8 >= 4)) :
                  (emode == 2) ? (i >= 2) : 1'b0;
    endtask

    // Sample k is taken after the k-th edge following the write (or reset release).
    task automatic run(input int w, input int fmode, input bit slow_on, input int emode);
        bit prev_cap = 1'b0;
        n_cap = 0; n_ivl = 0; first_cap = 0; first_ivl = 0; lag_err = 0; dbl_err = 0;
        set_inputs(0, fmode, slow_on, emode);
        for (int k = 1; k <= w; k++) begin
            @(negedge clk);
            if (cap_tick) begin
                n_cap++;
                if (first_cap == 0) first_cap = k;
                if (prev_cap) dbl_err++;
            end
            if (ivl_tick) begin
                n_ivl++;
                if (first_ivl == 0) first_ivl = k;
                if (!prev_cap) lag_err++;
            end
            prev_cap = cap_tick;
            set_inputs(k, fmode, slow_on, emode);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        main_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1", "cfg_q in reset", int'(cfg_q), 8'h8F);
            chk("R1", "ticks in reset", int'({cap_tick, ivl_tick}), 0);
        end
        rst = 1'b0;
        run(48, 1, 1'b0, 0);
        chk("R1", "default capture first tick (div6)", first_cap, 6);
        chk("R1", "default capture count", n_cap, 8);
        chk("R1", "default chained interval first tick", first_ivl, 25);
        chk("R1", "default chained interval count", n_ivl, 1);
    endtask

    task automatic t_ratios;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] v;
            v = {c[1:0], 2'b00, c[1:0], 2'b00};
            write_cfg(8'hFF);
            write_cfg(v);
            chk("R2", "cfg_q after write", int'(cfg_q), int'(v));
            run(48, 1, 1'b0, 0);
            chk("R3", $sformatf("capture first tick code %0d", c), first_cap, 2 * (c + 1));
            chk("R3", $sformatf("capture count code %0d", c), n_cap, 48 / (2 * (c + 1)));
            chk("R6", $sformatf("interval first tick code %0d", c), first_ivl, c + 1);
            chk("R6", $sformatf("interval count code %0d", c), n_ivl, 48 / (c + 1));
            chk("R9", $sformatf("capture single-cycle code %0d", c), dbl_err, 0);
        end
    endtask

    task automatic t_gapped;
        write_cfg(8'hFF);
        write_cfg(8'h08);
        run(40, 2, 1'b0, 0);
        chk("R9", "gapped capture first tick", first_cap, 3);
        chk("R9", "gapped capture count", n_cap, 10);
        chk("R9", "gapped interval first tick", first_ivl, 5);
        chk("R9", "gapped interval count", n_ivl, 6);
    endtask

    task automatic t_slow;
        write_cfg(8'hFF);
        write_cfg(8'h6A);
        chk("R2", "cfg_q after slow write", int'(cfg_q), 8'h6A);
        run(60, 1, 1'b1, 0);
        chk("R4", "slow capture first tick", first_cap, 16);
        chk("R4", "slow capture count", n_cap, 3);
        chk("R7", "slow interval first tick", first_ivl, 11);
        chk("R7", "slow interval count", n_ivl, 4);
    endtask

    task automatic t_ext_square;
        write_cfg(8'hFF);
        write_cfg(8'h11);
        run(80, 1, 1'b1, 1);
        chk("R8", "external interval first tick", first_ivl, 7);
        chk("R8", "external interval count", n_ivl, 8);
        chk("R4", "external capture first tick", first_cap, 15);
        chk("R4", "external capture count", n_cap, 4);
    endtask

    task automatic t_ext_held;
        write_cfg(8'hFF);
        write_cfg(8'h11);
        run(30, 0, 1'b0, 2);
        chk("R8", "held pin interval count", n_ivl, 1);
        chk("R8", "held pin interval tick edge", first_ivl, 5);
        chk("R8", "held pin capture count", n_cap, 0);
    endtask

    task automatic t_disabled;
        write_cfg(8'hFF);
        write_cfg(8'h3F);
        run(40, 1, 1'b1, 1);
        chk("R5", "capture off count", n_cap, 0);
        chk("R7", "chained interval with capture off", n_ivl, 0);
    endtask

    task automatic t_chain;
        write_cfg(8'hFF);
        write_cfg(8'h07);
        run(48, 1, 1'b0, 0);
        chk("R7", "chain capture count", n_cap, 24);
        chk("R7", "chain interval first tick", first_ivl, 5);
        chk("R7", "chain interval count", n_ivl, 11);
        chk("R7", "chain interval follows capture tick", lag_err, 0);
    endtask

    task automatic t_restart;
        write_cfg(8'hFF);
        write_cfg(8'h40);
        run(6, 1, 1'b0, 0);
        chk("R10", "base capture first tick", first_cap, 4);
        // Only the interval fields change: capture keeps its phase.
        write_cfg(8'h44);
        run(8, 1, 1'b0, 0);
        chk("R10", "capture phase kept", first_cap, 1);
        chk("R10", "capture count kept", n_cap, 2);
        chk("R10", "interval restarted first tick", first_ivl, 2);
        chk("R10", "interval restarted count", n_ivl, 4);
        // Only the capture fields change: capture restarts, interval keeps phase.
        write_cfg(8'hC4);
        run(16, 1, 1'b0, 0);
        chk("R10", "capture restarted first tick (div8)", first_cap, 8);
        chk("R3", "capture div8 count", n_cap, 2);
        chk("R10", "interval phase kept", first_ivl, 1);
        chk("R10", "interval count kept", n_ivl, 8);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_ratios();
        t_gapped();
        t_slow();
        t_ext_square();
        t_ext_held();
        t_disabled();
        t_chain();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule